// File: doc/BRIEF.md
# Two-Bit-Step Operand Normalizer

This block prepares an unsigned operand for a reciprocal-square-root unit. When a start pulse arrives while the block is idle, it captures the operand. It then shifts the operand left by two bit positions once per clock, and stops as soon as either of the two top bits is set. A nonzero 16-bit operand therefore ends between 0x4000 and 0xFFFF. The step count is reported next to the normalized value. An all-zero operand is caught inside the same loop and flagged, because its reciprocal square root has no finite value.

Scaling the input by four scales the reciprocal square root by one half. So a result computed on the normalized operand is restored by shifting it left one bit per step. The block provides this shift as a combinational path that uses the stored step count and saturates at the output width. A done pulse marks each finished normalization. Start is ignored while the block is busy.

Top module: `rsqrt_prenorm`

## Requirements
- R1: After reset, busy_o, done_o and zero_o are 0, steps_o is 0 and norm_o is 0.
- R2: A start_i sampled high while busy_o is 0 captures operand_i, and busy_o is 1 from the next cycle until the done cycle.
- R3: Each cycle of the loop shifts the operand left by exactly two bits. The loop stops when bit W-1 or bit W-2 is 1, so a nonzero operand ends in norm_o between 0x4000 and 0xFFFF.
- R4: steps_o is the number of two-bit shifts taken, 0 to 7. done_o is high in the cycle that follows the (steps+1)-th rising edge after the edge that sampled start.
- R5: An all-zero operand finishes on the first loop cycle with zero_o = 1, steps_o = 0 and norm_o = 0.
- R6: done_o is high for exactly one cycle. norm_o, steps_o and zero_o hold their values until the next accepted start.
- R7: start_i is ignored while busy_o is 1, and the result in progress is not disturbed.
- R8: res_o equals res_i shifted left by steps_o. If any 1 bit would be shifted out, res_o is all ones.
- R9: zero_o is 0 after the normalization of a nonzero operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| operand_i | input | W | Unsigned operand |
| busy_o | output | 1 | Normalization in progress |
| done_o | output | 1 | One-cycle completion pulse |
| norm_o | output | W | Normalized operand |
| steps_o | output | $clog2(W/2) | Number of two-bit steps taken |
| zero_o | output | 1 | Operand was zero |
| res_i | input | W | Result computed on the normalized operand |
| res_o | output | W | Denormalized, saturated result |

## Verification
The bench covers both ends of the step range. An operand of 1 needs seven steps, and an operand with the top bit set needs none. A loop that tests only bit W-1, or stops one step early or late, would report the wrong count and leave a value outside 0x4000 to 0xFFFF. A zero operand has to end at once with the flag set; a loop that never checks for zero would keep shifting until its counter wrapped. The bench also pulses start during a long run, where a block that accepts it would lose the result in progress. It drives res_i values that lose bits under the shift, where a plain shifter would return truncated results instead of all ones.

// File: rtl/rsqrt_prenorm.sv
module rsqrt_prenorm #(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [W-1:0]                operand_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [W-1:0]                norm_o,
  output logic [$clog2(W/2)-1:0]      steps_o,
  output logic                        zero_o,
  input  logic [W-1:0]                res_i,
  output logic [W-1:0]                res_o
);
  localparam int CW = $clog2(W/2);

  logic          busy_q, done_q, zero_q;
  logic [W-1:0]  val_q;
  logic [CW-1:0] cnt_q;
  logic [2*W-1:0] wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      zero_q <= 1'b0;
      val_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          val_q  <= operand_i;
          cnt_q  <= '0;
          zero_q <= 1'b0;
          busy_q <= 1'b1;
        end
      end else if (|val_q[W-1:W-2]) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (val_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        zero_q <= 1'b1;
      end else begin
        val_q <= val_q << 2;
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign wide    = {{W{1'b0}}, res_i} << cnt_q;
  assign res_o   = (|wide[2*W-1:W]) ? {W{1'b1}} : wide[W-1:0];
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign norm_o  = val_q;
  assign steps_o = cnt_q;
  assign zero_o  = zero_q;
endmodule

// File: rtl/rsqrt_prenorm_chk.sv
module rsqrt_prenorm_chk #(
  parameter int W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [W-1:0]           norm_o,
  input logic [$clog2(W/2)-1:0] steps_o,
  input logic                   zero_o,
  input logic [W-1:0]           res_i,
  input logic [W-1:0]           res_o
);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r2_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !zero_o) |-> (norm_o[W-1:W-2] != 2'b00));
  a_r5_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && zero_o) |-> (norm_o == '0 && steps_o == '0));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !done_o) |=> ($stable(norm_o) && $stable(steps_o) && $stable(zero_o)));
  a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (steps_o == '0) |-> (res_o == res_i));
endmodule

bind rsqrt_prenorm rsqrt_prenorm_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .norm_o(norm_o), .steps_o(steps_o), .zero_o(zero_o),
  .res_i(res_i), .res_o(res_o));

// File: tb/rsqrt_prenorm_tb_top.sv
module rsqrt_prenorm_tb_top;
  localparam int W = 16;
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {16'h8000, 16'h8000, 16'd0},
    {16'h4000, 16'h4000, 16'd0},
    {16'h3FFF, 16'hFFFC, 16'd1},
    {16'h1234, 16'h48D0, 16'd1},
    {16'h0100, 16'h4000, 16'd3},
    {16'h0200, 16'h8000, 16'd3},
    {16'h00FF, 16'hFF00, 16'd4},
    {16'h0005, 16'h5000, 16'd6},
    {16'h0003, 16'hC000, 16'd7},
    {16'h0001, 16'h4000, 16'd7}
  };

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [W-1:0] operand_i = '0, res_i = '0;
  logic busy_o, done_o, zero_o;
  logic [W-1:0] norm_o, res_o;
  logic [2:0] steps_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rsqrt_prenorm #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
    .busy_o(busy_o), .done_o(done_o), .norm_o(norm_o), .steps_o(steps_o),
    .zero_o(zero_o), .res_i(res_i), .res_o(res_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] op, input int exp_steps, output int lat);
    @(negedge clk);
    operand_i = op;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    if (exp_steps < 0) lat = lat;
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 zero", zero_o, 0);
    chk("R1 steps", steps_o, 0);
    chk("R1 norm", norm_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    operand_i = 16'h0001;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", busy_o, 1);
    while (!done_o) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][47:32], int'(VEC[i][15:0]), lat);
      chk("R3 norm", norm_o, VEC[i][31:16]);
      chk("R4 steps", steps_o, VEC[i][15:0]);
      chk("R4 latency", lat, VEC[i][15:0] + 2);
      chk("R9 zero clear", zero_o, 0);
      @(negedge clk);
      chk("R6 done one cycle", done_o, 0);
      chk("R6 hold norm", norm_o, VEC[i][31:16]);
    end

    run(16'h0000, 0, lat);
    chk("R5 zero flag", zero_o, 1);
    chk("R5 zero steps", steps_o, 0);
    chk("R5 zero norm", norm_o, 0);
    chk("R5 latency", lat, 2);

    run(16'h0200, 3, lat);
    res_i = 16'h0123; #1;
    chk("R8 shift by 3", res_o, 16'h0918);
    res_i = 16'h2001; #1;
    chk("R8 saturate by 3", res_o, 16'hFFFF);
    run(16'h0001, 7, lat);
    res_i = 16'h01FF; #1;
    chk("R8 shift by 7", res_o, 16'hFF80);
    res_i = 16'h0200; #1;
    chk("R8 saturate by 7", res_o, 16'hFFFF);

    @(negedge clk);
    operand_i = 16'h0001;
    start_i = 1'b1;
    @(negedge clk);
    operand_i = 16'h8000;
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk("R7 start ignored norm", norm_o, 16'h4000);
    chk("R7 start ignored steps", steps_o, 7);
    repeat (4) @(negedge clk);
    chk("R6 hold steps", steps_o, 7);
    chk("R6 idle", busy_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule